// File: doc/BRIEF.md
# Buffered ADC Trigger Compare Unit

This block sits beside a 16-bit timer counter that runs up and down as a triangle wave. It holds two active compare values, A and B. When the counter value matches one of them, the block sends a start request to an A/D converter. There is one request output for A and one for B. Software never writes the active values directly while a waveform is running. Instead it writes a shadow (buffer) register for each channel. The shadow contents move into the active compare registers at the counter's turning points, the crest and the trough. The trigger positions therefore change only at a turning point, so one half-period never mixes an old and a new value.

A mode input selects how a buffer write is applied. With buffered transfer on, a buffer write waits for the next crest or trough strobe. With buffered transfer off, a buffer write goes into the active compare register at once. The four registers are read and written over a small word-addressed bus. Only full 16-bit accesses take effect. A narrower access is rejected and reported on an error output.

Top module: `adc_trig_cmp`

## Requirements
- R1: After reset, compare A, compare B, buffer A and buffer B all read 16'hFFFF, and both request outputs and err_o are low.
- R2: A bus access with req_i=1 and word_i=1 returns the addressed register on rdata_o in the same cycle. Word offset 0 is compare A, 1 is compare B, 2 is buffer A and 3 is buffer B. When there is no word access, rdata_o is 0.
- R3: A word write to offset 0 or 1 loads that compare register at the next clock edge. If a transfer strobe occurs in the same cycle, the direct write takes precedence.
- R4: An access with req_i=1 and word_i=0 changes no register, and err_o is high for exactly the following cycle.
- R5: With xfer_en_i=1, a word write to a buffer changes only that buffer. The matching compare register keeps its value until a crest or trough strobe.
- R6: With xfer_en_i=1, a cycle with crest_i or trough_i high copies buffer A into compare A and buffer B into compare B.
- R7: If a buffer is written in the same cycle as a transfer strobe with xfer_en_i=1, the compare register receives the newly written value.
- R8: With xfer_en_i=0, a buffer write updates both the buffer and its compare register, and crest or trough strobes cause no transfer.
- R9: A request output goes high for one cycle, in the cycle after the first cycle in which cnt_i equals its compare register. While the count stays equal, including a hold across a crest or trough, no further request is raised.
- R10: Channels A and B detect matches independently, each on its own compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write (1) or read (0) |
| word_i | input | 1 | Access is a full 16-bit word |
| addr_i | input | 2 | Word offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| err_o | output | 1 | Rejected narrow access, one cycle late |
| xfer_en_i | input | 1 | Buffered transfer mode enable |
| cnt_i | input | 16 | Timer counter value |
| crest_i | input | 1 | Single-cycle strobe at the counter crest |
| trough_i | input | 1 | Single-cycle strobe at the counter trough |
| adc_req_a_o | output | 1 | ADC start request from compare A |
| adc_req_b_o | output | 1 | ADC start request from compare B |

## Verification
Read data is combinational, so the bench compares rdata_o 1 ns after it drives an access, before the next edge. A register write, a transfer or a rejected access takes effect at the next rising edge. A match seen in one cycle appears on the request output after that same edge. The bench therefore computes the next state of its model from the inputs it applied, waits for the edge, and samples err_o and both request outputs 1 ns later. Directed readbacks one cycle after each write, and request pulse counts over a hand-built triangle, pin down the precedence and hold cases.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned ADDR_W = CH_W + 1;

  // addr[ADDR_W-1] selects buffer bank, low bits select channel
  typedef enum logic [ADDR_W-1:0] {
    REG_CMP_A = 2'd0,
    REG_CMP_B = 2'd1,
    REG_BUF_A = 2'd2,
    REG_BUF_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/adc_trig_regif.sv
module adc_trig_regif
  import adc_trig_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic                       word_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CH-1:0][DW-1:0]  cmp_i,
  input  logic [NUM_CH-1:0][DW-1:0]  buf_i,
  output logic [NUM_CH-1:0]          cmp_we_o,
  output logic [NUM_CH-1:0]          buf_we_o,
  output logic [DW-1:0]              rdata_o,
  output logic                       err_o
);
  logic            acc_ok;
  logic            wr_ok;
  logic            bank_buf;
  logic [CH_W-1:0] ch_sel;
  logic            err_q;

  assign acc_ok   = req_i & word_i;
  assign wr_ok    = acc_ok & we_i;
  assign bank_buf = addr_i[ADDR_W-1];
  assign ch_sel   = addr_i[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign cmp_we_o[i] = wr_ok & ~bank_buf & (ch_sel == CH_W'(i));
    assign buf_we_o[i] = wr_ok &  bank_buf & (ch_sel == CH_W'(i));
  end

  always_comb begin
    rdata_o = '0;
    if (acc_ok) rdata_o = bank_buf ? buf_i[ch_sel] : cmp_i[ch_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= req_i & ~word_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmp_we_i,
  input  logic          buf_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_en_i,
  input  logic          strobe_i,
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] cmp_o,
  output logic [DW-1:0] buf_o,
  output logic          req_o
);
  logic [DW-1:0] cmp_q, buf_q;
  logic          hit, hit_q, req_q;

  assign hit = (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '1;
      cmp_q <= '1;
      hit_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (buf_we_i) buf_q <= wdata_i;
      // direct write > immediate-mode write > turning-point transfer
      if (cmp_we_i)                    cmp_q <= wdata_i;
      else if (buf_we_i && !xfer_en_i) cmp_q <= wdata_i;
      else if (xfer_en_i && strobe_i)  cmp_q <= buf_we_i ? wdata_i : buf_q;
      hit_q <= hit;
      req_q <= hit & ~hit_q;
    end
  end

  assign cmp_o = cmp_q;
  assign buf_o = buf_q;
  assign req_o = req_q;
endmodule

// File: rtl/adc_trig_cmp.sv
module adc_trig_cmp
  import adc_trig_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  input  logic              xfer_en_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              crest_i,
  input  logic              trough_i,
  output logic              adc_req_a_o,
  output logic              adc_req_b_o
);
  logic [NUM_CH-1:0][DW-1:0] cmp_q;
  logic [NUM_CH-1:0][DW-1:0] buf_q;
  logic [NUM_CH-1:0]         cmp_we, buf_we, req;
  logic                      strobe;

  assign strobe = crest_i | trough_i;

  adc_trig_regif #(.DW(DW)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .word_i   (word_i),
    .addr_i   (addr_i),
    .cmp_i    (cmp_q),
    .buf_i    (buf_q),
    .cmp_we_o (cmp_we),
    .buf_we_o (buf_we),
    .rdata_o  (rdata_o),
    .err_o    (err_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    adc_trig_chan #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmp_we_i  (cmp_we[i]),
      .buf_we_i  (buf_we[i]),
      .wdata_i   (wdata_i),
      .xfer_en_i (xfer_en_i),
      .strobe_i  (strobe),
      .cnt_i     (cnt_i),
      .cmp_o     (cmp_q[i]),
      .buf_o     (buf_q[i]),
      .req_o     (req[i])
    );
  end

  assign adc_req_a_o = req[0];
  assign adc_req_b_o = req[1];
endmodule

// File: rtl/adc_trig_cmp_chk.sv
module adc_trig_cmp_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          word_i,
  input logic          xfer_en_i,
  input logic          crest_i,
  input logic          trough_i,
  input logic [DW-1:0] cnt_i,
  input logic          err_o,
  input logic          adc_req_a_o,
  input logic          adc_req_b_o,
  input logic [DW-1:0] cmp_a,
  input logic [DW-1:0] cmp_b,
  input logic [DW-1:0] buf_a,
  input logic [DW-1:0] buf_b
);
  // R4
  err_follows_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !word_i));

  // R4
  byte_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !word_i) |-> ($stable(buf_a) && $stable(buf_b)));

  // R6
  turn_point_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(xfer_en_i && (crest_i || trough_i) && !(req_i && we_i))
      |-> (cmp_a == $past(buf_a) && cmp_b == $past(buf_b)));

  // R8
  no_xfer_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!xfer_en_i && !(req_i && we_i)) |-> ($stable(cmp_a) && $stable(cmp_b)));

  // R9
  req_a_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_a_o |-> $past(cnt_i == cmp_a));

  // R10
  req_b_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_b_o |-> $past(cnt_i == cmp_b));
endmodule

bind adc_trig_cmp adc_trig_cmp_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .word_i      (word_i),
  .xfer_en_i   (xfer_en_i),
  .crest_i     (crest_i),
  .trough_i    (trough_i),
  .cnt_i       (cnt_i),
  .err_o       (err_o),
  .adc_req_a_o (adc_req_a_o),
  .adc_req_b_o (adc_req_b_o),
  .cmp_a       (cmp_q[0]),
  .cmp_b       (cmp_q[1]),
  .buf_a       (buf_q[0]),
  .buf_b       (buf_q[1])
);

// File: tb/adc_trig_cmp_tb.sv
module adc_trig_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = 31;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        err_o;
  logic        xfer_en_i = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        crest_i = 1'b0, trough_i = 1'b0;
  logic        adc_req_a_o, adc_req_b_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cmp [2];
  logic [15:0] m_buf [2];
  logic        m_hit [2];
  logic [15:0] last_rd;
  int          pa, pb;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_trig_cmp u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .word_i, .addr_i, .wdata_i, .rdata_o, .err_o,
    .xfer_en_i, .cnt_i, .crest_i, .trough_i, .adc_req_a_o, .adc_req_b_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input bit rq, input bit wd, input logic [1:0] a);
    if (!(rq && wd)) return 16'h0;
    return a[1] ? m_buf[a[0]] : m_cmp[a[0]];
  endfunction

  // one cycle: drive after negedge, check comb read, then registered outputs after edge
  task automatic cyc(input bit rq, input bit we, input bit wd, input logic [1:0] a,
                     input logic [15:0] d, input bit xe, input logic [15:0] c,
                     input bit cr, input bit tr);
    logic [15:0] n_cmp [2];
    logic [15:0] n_buf [2];
    logic        n_hit [2];
    logic        n_req [2];
    logic        n_err;
    req_i = rq; we_i = we; word_i = wd; addr_i = a; wdata_i = d;
    xfer_en_i = xe; cnt_i = c; crest_i = cr; trough_i = tr;
    #1;
    last_rd = rdata_o;
    chk("R2 rdata", rdata_o, exp_rd(rq, wd, a));
    for (int ch = 0; ch < 2; ch++) begin
      bit cw = rq && wd && we && !a[1] && (a[0] == ch[0]);
      bit bw = rq && wd && we &&  a[1] && (a[0] == ch[0]);
      n_hit[ch] = (c == m_cmp[ch]);
      n_req[ch] = n_hit[ch] && !m_hit[ch];
      n_buf[ch] = bw ? d : m_buf[ch];
      if (cw)                  n_cmp[ch] = d;
      else if (bw && !xe)      n_cmp[ch] = d;
      else if (xe && (cr||tr)) n_cmp[ch] = bw ? d : m_buf[ch];
      else                     n_cmp[ch] = m_cmp[ch];
    end
    n_err = rq && !wd;
    @(posedge clk_i);
    #1;
    for (int ch = 0; ch < 2; ch++) begin
      m_cmp[ch] = n_cmp[ch]; m_buf[ch] = n_buf[ch]; m_hit[ch] = n_hit[ch];
    end
    chk("R9 req_a", {15'd0, adc_req_a_o}, {15'd0, n_req[0]});
    chk("R10 req_b", {15'd0, adc_req_b_o}, {15'd0, n_req[1]});
    chk("R4 err", {15'd0, err_o}, {15'd0, n_err});
    if (adc_req_a_o) pa++;
    if (adc_req_b_o) pb++;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input bit xe);
    cyc(1, 1, 1, a, d, xe, 16'h8000, 0, 0);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    cyc(1, 0, 1, a, 16'h0, xfer_en_i, 16'h8000, 0, 0);
    chk(tag, last_rd, exp);
  endtask

  task automatic cnt_step(input logic [15:0] c, input bit cr, input bit tr);
    cyc(0, 0, 1, 2'd0, 16'h0, xfer_en_i, c, cr, tr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pos, up, xe;
    void'($urandom(32'd4321));
    for (int ch = 0; ch < 2; ch++) begin
      m_cmp[ch] = 16'hFFFF; m_buf[ch] = 16'hFFFF; m_hit[ch] = 1'b0;
    end
    pa = 0; pb = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 req_a reset", {15'd0, adc_req_a_o}, 16'd0);
    chk("R1 req_b reset", {15'd0, adc_req_b_o}, 16'd0);
    chk("R1 err reset", {15'd0, err_o}, 16'd0);
    rst_ni = 1'b1;
    // R1 reset values
    rd_chk(2'd0, 16'hFFFF, "R1 cmp_a");
    rd_chk(2'd1, 16'hFFFF, "R1 cmp_b");
    rd_chk(2'd2, 16'hFFFF, "R1 buf_a");
    rd_chk(2'd3, 16'hFFFF, "R1 buf_b");
    // R5 buffered write holds
    xfer_en_i = 1'b1;
    wr(2'd2, 16'd100, 1);
    rd_chk(2'd0, 16'hFFFF, "R5 cmp_a held");
    rd_chk(2'd2, 16'd100, "R5 buf_a");
    // R6 crest transfer
    cyc(0, 0, 1, 2'd0, 16'h0, 1, 16'h8000, 1, 0);
    rd_chk(2'd0, 16'd100, "R6 cmp_a after crest");
    rd_chk(2'd1, 16'hFFFF, "R6 cmp_b after crest");
    // R7 write colliding with trough
    cyc(1, 1, 1, 2'd3, 16'd200, 1, 16'h8000, 0, 1);
    rd_chk(2'd1, 16'd200, "R7 cmp_b new value");
    // R3 direct write, and precedence over transfer
    wr(2'd0, 16'd300, 1);
    rd_chk(2'd0, 16'd300, "R3 cmp_a direct");
    cyc(1, 1, 1, 2'd0, 16'd5, 1, 16'h8000, 1, 0);
    rd_chk(2'd0, 16'd5, "R3 direct beats transfer");
    // R4 byte write ignored
    cyc(1, 1, 0, 2'd2, 16'd7, 1, 16'h8000, 0, 0);
    rd_chk(2'd2, 16'd100, "R4 buf_a unchanged");
    // R8 immediate mode
    xfer_en_i = 1'b0;
    wr(2'd2, 16'd50, 0);
    rd_chk(2'd0, 16'd50, "R8 cmp_a immediate");
    wr(2'd0, 16'd60, 0);
    cyc(0, 0, 1, 2'd0, 16'h0, 0, 16'h8000, 1, 0);
    rd_chk(2'd0, 16'd60, "R8 no transfer when off");
    // R9/R10 pulse counts over a triangle with a held crest
    wr(2'd0, 16'd10, 0);
    wr(2'd1, 16'd12, 0);
    pa = 0; pb = 0;
    for (int v = 8; v <= 12; v++) cnt_step(16'(v), 0, 0);
    cnt_step(16'd12, 1, 0);
    cnt_step(16'd12, 0, 0);
    for (int v = 11; v >= 8; v--) cnt_step(16'(v), 0, 0);
    chk("R9 pulses A over up and down", 16'(pa), 16'd2);
    chk("R9 held crest gives one B pulse", 16'(pb), 16'd1);
    // random triangle with random bus traffic
    pos = 0; up = 1; xe = 1;
    for (int n = 0; n < 4000; n++) begin
      bit cr = up && pos == TOP;
      bit tr = !up && pos == 0;
      bit rq = ($urandom % 4) == 0;
      bit we = $urandom % 2;
      bit wd = ($urandom % 8) != 0;
      logic [1:0] a = 2'($urandom);
      logic [15:0] d = (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % (TOP + 1));
      if ((n % 250) == 0) xe = $urandom % 2;
      cyc(rq, we, wd, a, d, xe[0], 16'(pos), cr, tr);
      if (($urandom % 16) != 0) begin
        if (cr) up = 0;
        else if (tr) up = 1;
        else pos = up ? pos + 1 : pos - 1;
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule